// File: doc/BRIEF.md
# Binary Field Squaring Unit

This unit squares an element of the binary extension field GF(2^233), with elements held in polynomial basis. In characteristic two, squaring a polynomial needs no partial products. Every coefficient simply moves to twice its old exponent. The unit therefore spreads the input bits apart with a zero between each adjacent pair. This gives a double-length polynomial of degree at most 464. The unit then folds that polynomial back into the field, modulo the fixed trinomial x^233 + x^74 + 1.

The whole square is one combinational cone that ends in an output register. A result therefore appears one clock after the operand is offered with its valid strobe. This lets a field-arithmetic datapath issue a new square every cycle. The field degree `M` and the middle exponent `K` of the trinomial are parameters. The number of fold passes and the width of each pass are derived from them at elaboration. The defaults give the 233-bit field, and smaller trinomials can be used for exhaustive testing.

Top module: `gf2sq_unit`

## Requirements
- R1: `out_valid` is 1 in the cycle after a clock edge at which `in_valid` was 1, and 0 in the cycle after an edge at which `in_valid` was 0.
- R2: While `rst_n` is 0, `out_valid` is 0; the clear takes effect at once on the falling edge of `rst_n`, without waiting for a clock.
- R3: One cycle after an edge that accepts `in_data` (bit i is the coefficient of x^i), `out_data` holds the square of `in_data` reduced modulo x^M + x^K + 1, with bit i the coefficient of x^i.
- R4: Input bit j lands on exponent 2j of the unreduced square, with zeros at odd exponents. For example, an operand whose low four bits are 1101 and whose other bits are zero gives 01010001 (0x51) in the low byte and zeros above.
- R5: Every coefficient at exponent i >= M is folded into exponents i-M and i-M+K. Folding repeats until no coefficient at or above x^M remains, so a single-bit operand x^j gives x^(2j) fully reduced for every j in 0..M-1.
- R6: Squaring the zero element gives zero and squaring the one element gives one.
- R7: In a cycle after an edge at which `in_valid` was 0, `out_data` keeps its previous value whatever `in_data` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe; `in_data` is taken at this edge |
| in_data | input | M | Field element to be squared, polynomial basis |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | M | Reduced square, held until the next accepted operand |

## Verification
The bench checks the fold boundary in two ways. It sweeps every single-bit operand of the full-size field. It also sweeps every operand of two small trinomials, one that needs a single fold pass and one that needs two. A design that stops after one fold would leave coefficients of x^233 and above out of the result. A design with the middle tap off by one would misplace bits only for operands that have high-order bits set. The expected value comes from a bit-serial carry-less product of the operand with itself, followed by a top-down reduction. It does not use interleaving, so a wrong spread order (for example, bits landing on odd exponents) shows up even when the worked 1101 case is the only small input. Idle cycles with changing `in_data`, and a reset raised in the middle of a cycle, catch a result register with no enable and a reset that waits for the clock.

// File: rtl/gf2sq_pkg.sv
package gf2sq_pkg;

  // Number of fold passes needed to bring the top exponent 2M-2 below M.
  function automatic int fold_count(input int m, input int k);
    int top;
    int n;
    top = 2 * m - 2;
    n   = 0;
    for (int i = 0; i < 256; i++) begin
      if (top >= m) begin
        top = top - m + k;
        n   = n + 1;
      end
    end
    return n;
  endfunction

  // Exact bit width of the polynomial after s fold passes (s = 0: spread).
  function automatic int pass_width(input int m, input int k, input int s);
    int top;
    top = 2 * m - 2;
    for (int i = 0; i < 256; i++) begin
      if (i < s && top >= m) top = top - m + k;
    end
    return (top + 1 > m) ? top + 1 : m;
  endfunction

endpackage

// File: rtl/gf2sq_spread.sv
module gf2sq_spread #(
  parameter int M = 233,
  localparam int W = 2 * M - 1
) (
  input  logic [M-1:0] a,
  output logic [W-1:0] p
);

  // Coefficient j moves to exponent 2j.
  for (genvar j = 0; j < M; j++) begin : g_even
    assign p[2*j] = a[j];
  end

  // Odd exponents of a square are always empty.
  for (genvar j = 0; j < M - 1; j++) begin : g_odd
    assign p[2*j+1] = 1'b0;
  end

endmodule

// File: rtl/gf2sq_fold.sv
module gf2sq_fold #(
  parameter int M  = 233,
  parameter int K  = 74,
  parameter int WI = 465,
  parameter int WO = 306
) (
  input  logic [WI-1:0] v,
  output logic [WO-1:0] r
);

  localparam int H = WI - M;

  logic [M-1:0] lo;
  logic [H-1:0] hi;

  assign lo = v[M-1:0];
  assign hi = v[WI-1:M];

  // x^M == x^K + 1: each high coefficient lands at offsets 0 and K.
  always_comb begin
    r = WO'(lo) ^ WO'(hi) ^ (WO'(hi) << K);
  end

endmodule

// File: rtl/gf2sq_unit.sv
module gf2sq_unit
  import gf2sq_pkg::*;
#(
  parameter int M = 233,
  parameter int K = 74
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [M-1:0] in_data,
  output logic         out_valid,
  output logic [M-1:0] out_data
);

  localparam int NP = fold_count(M, K);
  localparam int WS = pass_width(M, K, 0);

  logic [WS-1:0] spread;

  gf2sq_spread #(.M(M)) u_spread (
    .a(in_data),
    .p(spread)
  );

  for (genvar s = 0; s < NP; s++) begin : g_pass
    localparam int WI = pass_width(M, K, s);
    localparam int WO = pass_width(M, K, s + 1);
    logic [WO-1:0] res;
    if (s == 0) begin : g_head
      gf2sq_fold #(.M(M), .K(K), .WI(WI), .WO(WO)) u_fold (
        .v(spread),
        .r(res)
      );
    end else begin : g_tail
      gf2sq_fold #(.M(M), .K(K), .WI(WI), .WO(WO)) u_fold (
        .v(g_pass[s-1].res),
        .r(res)
      );
    end
  end

  logic [M-1:0] sq;
  assign sq = g_pass[NP-1].res;

  // Next-state logic
  logic         vld_d, vld_q;
  logic [M-1:0] dat_d, dat_q;

  always_comb begin
    vld_d = in_valid;
    dat_d = in_valid ? sq : dat_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) dat_q <= dat_d;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/gf2sq_unit_chk.sv
module gf2sq_unit_chk #(
  parameter int M = 233
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [M-1:0] in_data,
  input logic         out_valid,
  input logic [M-1:0] out_data
);

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_reset_clear_r2: assert property (@(posedge clk)
    !rst_n |-> !out_valid);

  p_zero_sq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == '0) |=> out_data == '0);

  p_one_sq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data == M'(1)) |=> out_data == M'(1));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

endmodule

bind gf2sq_unit gf2sq_unit_chk #(.M(M)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .in_valid(in_valid),
  .in_data(in_data),
  .out_valid(out_valid),
  .out_data(out_data)
);

// File: tb/test_gf2sq_unit.sv
module test_gf2sq_unit;

  logic clk;
  logic rst_n;

  logic         vb, v9, v7;
  logic [232:0] db;
  logic [8:0]   d9;
  logic [6:0]   d7;
  logic         ob_v, o9_v, o7_v;
  logic [232:0] ob;
  logic [8:0]   o9;
  logic [6:0]   o7;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [232:0] exp_b;
  logic [8:0]   exp_9;
  logic [6:0]   exp_7;

  gf2sq_unit #(.M(233), .K(74)) i_gf2sq_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(vb), .in_data(db),
    .out_valid(ob_v), .out_data(ob));

  gf2sq_unit #(.M(9), .K(4)) i_gf2sq_unit_m9 (
    .clk(clk), .rst_n(rst_n), .in_valid(v9), .in_data(d9),
    .out_valid(o9_v), .out_data(o9));

  gf2sq_unit #(.M(7), .K(1)) i_gf2sq_unit_m7 (
    .clk(clk), .rst_n(rst_n), .in_valid(v7), .in_data(d7),
    .out_valid(o7_v), .out_data(o7));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bit-serial carry-less product a*a, then top-down trinomial reduction.
  function automatic logic [232:0] ref_sq(input logic [232:0] a, input int m, input int k);
    logic [465:0] p;
    p = '0;
    for (int i = 0; i < m; i++)
      if (a[i]) p = p ^ ({233'b0, a} << i);
    for (int i = 2 * m - 2; i >= m; i--) begin
      if (p[i]) begin
        p[i]         = 1'b0;
        p[i - m]     = ~p[i - m];
        p[i - m + k] = ~p[i - m + k];
      end
    end
    return p[232:0];
  endfunction

  task automatic chk(input string req, input logic [232:0] act, input logic [232:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle on all three units, then check at the next falling edge.
  task automatic step(input logic v, input logic [232:0] ab, input logic [8:0] a9,
                      input logic [6:0] a7, input string req);
    vb = v; v9 = v; v7 = v;
    db = ab; d9 = a9; d7 = a7;
    if (v) begin
      exp_b = ref_sq(ab, 233, 74);
      exp_9 = ref_sq({224'b0, a9}, 9, 4)[8:0];
      exp_7 = ref_sq({226'b0, a7}, 7, 1)[6:0];
    end
    @(negedge clk);
    chk({req, " R1 valid"}, {232'b0, ob_v}, {232'b0, v});
    chk({req, " R1 valid m9"}, {232'b0, o9_v}, {232'b0, v});
    chk({req, " R1 valid m7"}, {232'b0, o7_v}, {232'b0, v});
    chk({req, " data"}, ob, exp_b);
    chk({req, " data m9"}, {224'b0, o9}, {224'b0, exp_9});
    chk({req, " data m7"}, {226'b0, o7}, {226'b0, exp_7});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [232:0] lf;
    rst_n = 1'b1;
    vb = 0; v9 = 0; v7 = 0;
    db = '0; d9 = '0; d7 = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 reset valid", {232'b0, ob_v}, '0);
    chk("R2 reset valid m9", {232'b0, o9_v}, '0);
    chk("R2 reset valid m7", {232'b0, o7_v}, '0);
    rst_n = 1'b1;

    // R6: zero and one
    step(1'b1, '0, '0, '0, "R6 zero");
    chk("R6 zero explicit", ob, '0);
    step(1'b1, 233'd1, 9'd1, 7'd1, "R6 one");
    chk("R6 one explicit", ob, 233'd1);
    chk("R6 one explicit m7", {226'b0, o7}, 233'd1);

    // R4: worked spread example
    step(1'b1, 233'b1101, 9'b1101, 7'b1101, "R4 spread");
    chk("R4 spread 1101", ob, 233'h51);
    chk("R4 spread 1101 m9", {224'b0, o9}, 233'h51);
    chk("R4 spread 1101 m7", {226'b0, o7}, 233'h51);

    // R5: every single-bit operand of the full field
    for (int j = 0; j < 233; j++)
      step(1'b1, 233'd1 << j, 9'd1 << (j % 9), 7'd1 << (j % 7), "R5 single bit");

    // R3: exhaustive small fields, varied large operands, back-to-back
    lf = 233'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978;
    for (int i = 0; i < 512; i++) begin
      step(1'b1, lf, 9'(i), 7'(i), "R3 sweep");
      lf = {lf[231:0], lf[232] ^ lf[150] ^ lf[73] ^ lf[0]};
    end
    step(1'b1, {233{1'b1}}, {9{1'b1}}, {7{1'b1}}, "R3 all ones");

    // R7: idle cycles with changing data hold the result
    for (int i = 0; i < 6; i++) begin
      step(1'b0, lf, 9'(i * 37), 7'(i * 19), "R7 hold");
      lf = {lf[231:0], lf[232] ^ lf[150] ^ lf[73] ^ lf[0]};
    end
    step(1'b1, lf, 9'h1AB, 7'h55, "R1 resume");

    // R2: asynchronous clear in mid-cycle
    #1 rst_n = 1'b0;
    #1;
    chk("R2 async clear", {232'b0, ob_v}, '0);
    chk("R2 async clear m9", {232'b0, o9_v}, '0);
    chk("R2 async clear m7", {232'b0, o7_v}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 233'h3 << 200, 9'h180, 7'h60, "R3 after reset");

    vb = 0; v9 = 0; v7 = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule